// File: doc/BRIEF.md
# Dual-Mask Interrupt Aggregator

The aggregator gathers 24 event inputs from peripheral functions into one interrupt line for a host. Each source passes through two independent gates. The first gate, the status mask, decides whether a rising edge on the source is recorded in a sticky status bit. The second gate, the line mask, decides whether a recorded status bit may raise the interrupt output. A source that is status-masked cannot reach the line at all, even when its line mask is open.

Sources, status bits and both mask sets are grouped into three byte-wide banks. Source n sits in bank n/8 at bit n%8. Bank A bit 0 is the power-button event and bank A bit 3 is the clock-alarm event. The host reaches the banks through a byte-wide register port with single-cycle write and read strobes. It clears status bits by writing ones to them.

Top module: `dual_mask_irq_agg`

## Requirements
- R1: After reset, `irq_o` is 0, every status byte reads 0x00, every line-mask byte reads 0xFF and every status-mask byte reads 0x00.
- R2: A 0-to-1 change on `ev_i[n]` sets the status bit of bank n/8, bit n%8, at that clock edge, provided the source's status-mask bit is 0. An input held high after its bit is cleared does not set the bit again.
- R3: While a source's status-mask bit is 1, its rising edges leave its status bit unchanged.
- R4: While a source's line-mask bit is 1, its status bit is still recorded but the source does not raise `irq_o`.
- R5: `irq_o` is a register. On each clock it takes the OR, over all 24 sources, of status AND NOT line-mask AND NOT status-mask, sampled at the previous edge.
- R6: A source whose status-mask bit is 1 never raises `irq_o`, even if its line-mask bit is 0 and its status bit was set before the mask was applied.
- R7: A write to a status byte (addresses 0x00, 0x01 and 0x02 for banks A, B and C) clears each bit written as 1 and leaves each bit written as 0 unchanged. Status bits change on no other write.
- R8: When a rising edge and a clear for the same status bit fall in the same cycle, the bit ends up set.
- R9: Line-mask bytes at 0x10 to 0x12 and status-mask bytes at 0x20 to 0x22 (bank A first) read back the last value written. They change only on a write.
- R10: Reads of any unmapped address return 0x00. Writes to unmapped addresses change no register.
- R11: `rdata_o` takes the addressed byte on the clock edge that samples `rd_en_i` high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 24 | Event inputs, source n in bank n/8 bit n%8 |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt line, active high |

## Verification
The assertions assume that `ev_i`, the strobes, the address and the write data are stable around each rising clock edge. They also assume that a status bit can only rise after `ev_i` for that source was high at the sampling edge. The bench changes every input on the falling edge and asserts at most one strobe per cycle. It creates edges by dropping an input for at least one cycle before raising it again, so that each intended edge is seen exactly once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_STS  = 2'd1,
      RGN_LMSK = 2'd2,
      RGN_SMSK = 2'd3
   } region_e;

   typedef struct packed {
      region_e    rgn;
      logic [7:0] idx;
   } decode_t;

   function automatic decode_t decode_region(input int unsigned addr,
                                             input int unsigned sts_base,
                                             input int unsigned lmsk_base,
                                             input int unsigned smsk_base,
                                             input int unsigned nbanks);
      decode_t d;
      d.rgn = RGN_NONE;
      d.idx = '0;
      if (addr >= sts_base && addr < sts_base + nbanks) begin
         d.rgn = RGN_STS;
         d.idx = 8'(addr - sts_base);
      end else if (addr >= lmsk_base && addr < lmsk_base + nbanks) begin
         d.rgn = RGN_LMSK;
         d.idx = 8'(addr - lmsk_base);
      end else if (addr >= smsk_base && addr < smsk_base + nbanks) begin
         d.rgn = RGN_SMSK;
         d.idx = 8'(addr - smsk_base);
      end
      return d;
   endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] ev_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= ev_i;
   end

   assign rise_o = ev_i & ~prev_q;
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] rise_i,
   input  logic [WIDTH-1:0] clr_i,
   input  logic             lmsk_we_i,
   input  logic             smsk_we_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] sts_o,
   output logic [WIDTH-1:0] lmsk_o,
   output logic [WIDTH-1:0] smsk_o,
   output logic             line_o
);
   logic [WIDTH-1:0] sts_q, lmsk_q, smsk_q, sts_d;

   // set wins over clear in the same cycle
   assign sts_d = (sts_q & ~clr_i) | (rise_i & ~smsk_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sts_q  <= '0;
         lmsk_q <= '1;
         smsk_q <= '0;
      end else begin
         sts_q <= sts_d;
         if (lmsk_we_i) lmsk_q <= wdata_i;
         if (smsk_we_i) smsk_q <= wdata_i;
      end
   end

   assign line_o = |(sts_q & ~lmsk_q & ~smsk_q);
   assign sts_o  = sts_q;
   assign lmsk_o = lmsk_q;
   assign smsk_o = smsk_q;
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
   import irq_agg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned STS_BASE  = 'h00,
   parameter int unsigned LMSK_BASE = 'h10,
   parameter int unsigned SMSK_BASE = 'h20
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic                          rd_en_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   input  logic [NUM_BANKS*DATA_W-1:0]   sts_i,
   input  logic [NUM_BANKS*DATA_W-1:0]   lmsk_i,
   input  logic [NUM_BANKS*DATA_W-1:0]   smsk_i,
   output logic [NUM_BANKS*DATA_W-1:0]   sts_clr_o,
   output logic [NUM_BANKS-1:0]          lmsk_we_o,
   output logic [NUM_BANKS-1:0]          smsk_we_o,
   output logic [DATA_W-1:0]             rdata_o
);
   decode_t          dec;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;

   assign dec = decode_region(int'(addr_i), STS_BASE, LMSK_BASE, SMSK_BASE, NUM_BANKS);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
      logic sel;
      assign sel = wr_en_i && (dec.idx == 8'(b));
      assign sts_clr_o[b*DATA_W +: DATA_W] = (sel && dec.rgn == RGN_STS) ? wdata_i : '0;
      assign lmsk_we_o[b] = sel && (dec.rgn == RGN_LMSK);
      assign smsk_we_o[b] = sel && (dec.rgn == RGN_SMSK);
   end

   always_comb begin
      rd_val = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (dec.idx == 8'(b)) begin
            unique case (dec.rgn)
               RGN_STS:  rd_val = sts_i [b*DATA_W +: DATA_W];
               RGN_LMSK: rd_val = lmsk_i[b*DATA_W +: DATA_W];
               RGN_SMSK: rd_val = smsk_i[b*DATA_W +: DATA_W];
               default:  rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_val;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/dual_mask_irq_agg.sv
module dual_mask_irq_agg #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STS_BASE  = 'h00,
   parameter int unsigned LMSK_BASE = 'h10,
   parameter int unsigned SMSK_BASE = 'h20,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] ev_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [BANK_W-1:0]  wdata_i,
   output logic [BANK_W-1:0]  rdata_o,
   output logic               irq_o
);
   initial begin
      assert (NUM_BANKS > 0 && BANK_W > 0)
         else $error("bank count and width must be non-zero");
      assert (STS_BASE + NUM_BANKS <= LMSK_BASE && LMSK_BASE + NUM_BANKS <= SMSK_BASE)
         else $error("register regions overlap or are out of order");
      assert (SMSK_BASE + NUM_BANKS <= (1 << ADDR_W))
         else $error("register map exceeds address space");
   end

   logic [NUM_SRC-1:0]   rise, sts_clr, sts_q, lmsk_q, smsk_q;
   logic [NUM_BANKS-1:0] lmsk_we, smsk_we, line;
   logic                 irq_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_edge_capture #(.WIDTH(BANK_W)) i_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .ev_i   (ev_i[b*BANK_W +: BANK_W]),
         .rise_o (rise[b*BANK_W +: BANK_W])
      );

      irq_agg_bank #(.WIDTH(BANK_W)) i_bank (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .rise_i    (rise[b*BANK_W +: BANK_W]),
         .clr_i     (sts_clr[b*BANK_W +: BANK_W]),
         .lmsk_we_i (lmsk_we[b]),
         .smsk_we_i (smsk_we[b]),
         .wdata_i   (wdata_i),
         .sts_o     (sts_q[b*BANK_W +: BANK_W]),
         .lmsk_o    (lmsk_q[b*BANK_W +: BANK_W]),
         .smsk_o    (smsk_q[b*BANK_W +: BANK_W]),
         .line_o    (line[b])
      );
   end

   irq_host_port #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (BANK_W),
      .NUM_BANKS (NUM_BANKS),
      .STS_BASE  (STS_BASE),
      .LMSK_BASE (LMSK_BASE),
      .SMSK_BASE (SMSK_BASE)
   ) i_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .sts_i     (sts_q),
      .lmsk_i    (lmsk_q),
      .smsk_i    (smsk_q),
      .sts_clr_o (sts_clr),
      .lmsk_we_o (lmsk_we),
      .smsk_we_o (smsk_we),
      .rdata_o   (rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |line;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
   parameter int unsigned NUM_SRC   = 24,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned STS_BASE  = 'h00,
   parameter int unsigned LMSK_BASE = 'h10,
   parameter int unsigned SMSK_BASE = 'h20
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] ev_i,
   input logic               wr_en_i,
   input logic               rd_en_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic [BANK_W-1:0]  rdata_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] sts,
   input logic [NUM_SRC-1:0] lmsk,
   input logic [NUM_SRC-1:0] smsk
);
   logic unmapped;
   assign unmapped = !((int'(addr_i) >= STS_BASE  && int'(addr_i) < STS_BASE  + NUM_BANKS) ||
                       (int'(addr_i) >= LMSK_BASE && int'(addr_i) < LMSK_BASE + NUM_BANKS) ||
                       (int'(addr_i) >= SMSK_BASE && int'(addr_i) < SMSK_BASE + NUM_BANKS));

   assert_rise_needs_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sts & ~$past(sts) & ~$past(ev_i)) == '0));

   assert_smask_blocks_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sts & ~$past(sts) & $past(smsk)) == '0));

   assert_all_line_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&lmsk) |=> !irq_o);

   // also covers R6: status-masked bits are excluded from the line term
   assert_irq_follows_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == $past(|(sts & ~lmsk & ~smsk)));

   assert_clear_needs_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ((~sts & $past(sts)) == '0));

   assert_masks_need_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(lmsk) && $stable(smsk)));

   assert_unmapped_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && unmapped) |=> (rdata_o == '0));

   assert_rdata_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));
endmodule

bind dual_mask_irq_agg irq_agg_checker #(
   .NUM_SRC   (NUM_SRC),
   .ADDR_W    (ADDR_W),
   .BANK_W    (BANK_W),
   .NUM_BANKS (NUM_BANKS),
   .STS_BASE  (STS_BASE),
   .LMSK_BASE (LMSK_BASE),
   .SMSK_BASE (SMSK_BASE)
) i_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .ev_i    (ev_i),
   .wr_en_i (wr_en_i),
   .rd_en_i (rd_en_i),
   .addr_i  (addr_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .sts     (sts_q),
   .lmsk    (lmsk_q),
   .smsk    (smsk_q)
);

// File: tb/test_dual_mask_irq_agg.sv
module test_dual_mask_irq_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] ev = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0, wdata = '0;
   logic [7:0]  rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [23:0] m_sts = '0, m_lm = '1, m_sm = '0, m_prev = '0;
   logic        m_irq = 1'b0;
   logic [7:0]  m_rd = '0;
   logic [23:0] ev_drv = '0;

   always #4 clk = ~clk;   // 125 MHz

   dual_mask_irq_agg i_dual_mask_irq_agg (
      .clk_i (clk), .rst_ni (rst_n), .ev_i (ev),
      .wr_en_i (wr_en), .rd_en_i (rd_en), .addr_i (addr), .wdata_i (wdata),
      .rdata_o (rdata), .irq_o (irq)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [7:0] a);
      if (a <= 8'h02)                  return m_sts[a*8 +: 8];
      if (a >= 8'h10 && a <= 8'h12)    return m_lm[(a-8'h10)*8 +: 8];
      if (a >= 8'h20 && a <= 8'h22)    return m_sm[(a-8'h20)*8 +: 8];
      return 8'h00;
   endfunction

   task automatic m_update(input logic wr, input logic rd, input logic [7:0] a,
                           input logic [7:0] d);
      logic [23:0] rise_v, clr, sm_old;
      logic        irq_n;
      rise_v = ev_drv & ~m_prev;
      clr    = '0;
      sm_old = m_sm;
      irq_n  = |(m_sts & ~m_lm & ~m_sm);
      if (rd) m_rd = m_read(a);
      if (wr) begin
         if (a <= 8'h02)                    clr[a*8 +: 8] = d;
         else if (a >= 8'h10 && a <= 8'h12) m_lm[(a-8'h10)*8 +: 8] = d;
         else if (a >= 8'h20 && a <= 8'h22) m_sm[(a-8'h20)*8 +: 8] = d;
      end
      m_sts  = (m_sts & ~clr) | (rise_v & ~sm_old);
      m_prev = ev_drv;
      m_irq  = irq_n;
   endtask

   // one clock: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [7:0] d, input string tag);
      wr_en = wr; rd_en = rd; addr = a; wdata = d; ev = ev_drv;
      @(posedge clk);
      m_update(wr, rd, a, d);
      @(negedge clk);
      chk({7'd0, irq}, {7'd0, m_irq}, {tag, " irq vs model (R5)"});
      chk(rdata, m_rd, {tag, " rdata vs model (R11)"});
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'h00, tag);
   endtask

   task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string tag);
      step(1'b0, 1'b1, a, 8'h00, tag);
      chk(rdata, exp, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
      step(1'b1, 1'b0, a, d, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all-reqs actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk({7'd0, irq}, 8'h00, "R1 irq after reset");
      rd_expect(8'h00, 8'h00, "R1 status A");
      rd_expect(8'h02, 8'h00, "R1 status C");
      rd_expect(8'h11, 8'hFF, "R1 line mask B");
      rd_expect(8'h22, 8'h00, "R1 status mask C");

      // R9 mask registers read back
      wr(8'h10, 8'h00, "R9 open line A");
      wr(8'h21, 8'hA5, "R9 smask B");
      rd_expect(8'h21, 8'hA5, "R9 smask B readback");
      rd_expect(8'h10, 8'h00, "R9 lmask A readback");

      // R2 alarm source (bank A bit 3), R5 line assertion
      ev_drv[3] = 1'b1;
      idle(2, "R2 alarm edge");
      chk({7'd0, irq}, 8'h01, "R5 irq raised by alarm");
      rd_expect(8'h00, 8'h08, "R2 alarm status");

      // R7 write-one-to-clear
      wr(8'h00, 8'h00, "R7 write zero");
      rd_expect(8'h00, 8'h08, "R7 zero write keeps bit");
      wr(8'h00, 8'h08, "R7 write one");
      rd_expect(8'h00, 8'h00, "R7 bit cleared, held level no re-set (R2)");
      idle(1, "R7 settle");
      chk({7'd0, irq}, 8'h00, "R7 irq falls after clear");

      // R4 line-masked source still records
      ev_drv[12] = 1'b1;
      idle(2, "R4 bank B bit 4");
      rd_expect(8'h01, 8'h10, "R4 status recorded under line mask");
      chk({7'd0, irq}, 8'h00, "R4 irq stays low");

      // R3 status-masked source not recorded (bank B bit 0, smask 0xA5)
      ev_drv[8] = 1'b1;
      idle(2, "R3 bank B bit 0");
      rd_expect(8'h01, 8'h10, "R3 masked edge not stored");

      // R6 late status mask removes line contribution
      wr(8'h12, 8'h00, "R6 open line C");
      ev_drv[17] = 1'b1;
      idle(2, "R6 bank C bit 1");
      chk({7'd0, irq}, 8'h01, "R6 irq before status mask");
      wr(8'h22, 8'h02, "R6 set status mask C bit 1");
      idle(2, "R6 settle");
      chk({7'd0, irq}, 8'h00, "R6 irq gone with status masked");
      rd_expect(8'h02, 8'h02, "R6 status bit kept");

      // R8 set beats clear (power-button source, bank A bit 0)
      ev_drv[0] = 1'b1;
      idle(1, "R8 first edge");
      ev_drv[0] = 1'b0;
      idle(1, "R8 drop");
      ev_drv[0] = 1'b1;
      wr(8'h00, 8'h01, "R8 edge with clear");
      rd_expect(8'h00, 8'h01, "R8 bit stays set");
      wr(8'h00, 8'h01, "R8 clear with level held");
      rd_expect(8'h00, 8'h00, "R8 cleared (R2 no re-set)");

      // R10 unmapped address
      rd_expect(8'h05, 8'h00, "R10 unmapped read");
      wr(8'h07, 8'hFF, "R10 unmapped write");
      wr(8'h13, 8'h00, "R10 unmapped write past line masks");
      rd_expect(8'h10, 8'h00, "R10 lmask A untouched");
      rd_expect(8'h11, 8'hFF, "R10 lmask B untouched");
      rd_expect(8'h21, 8'hA5, "R10 smask B untouched");

      // R11 read data holds without a strobe
      rd_expect(8'h11, 8'hFF, "R11 read");
      idle(3, "R11 hold");
      chk(rdata, 8'hFF, "R11 rdata held");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule